// File: doc/BRIEF.md
# Pulse-swallow programmable feedback divider

This block divides a fast input clock by a programmable ratio for the feedback path of a frequency synthesizer. It models a dual-modulus prescaler (divide by 64 or by 65) as a digital down-counter, and steers it with two down-counters: a 6-bit swallow counter holding A and a 12-bit main counter holding N. In each output period the prescaler first divides by 65 for A of its output ticks, then by 64 for the remaining N−A ticks. One period therefore lasts 64·N + A input clock cycles. A one-cycle pulse, fp, marks the last cycle of each period. The modulus-control line is brought out as the signal that would drive an external prescaler.

A new (A, N) pair is captured with a load strobe into a holding register. It is taken into use only at the next period boundary, so a period in progress always completes at its old length. A pair with N below 5, or with N smaller than A, cannot give the stated ratio. Such a pair raises an error flag and is discarded at the boundary, and the running ratio stays as it was.

Top module: `psd_divider`

## Requirements
- R1: While rst is high and in the first cycle after it falls, fp and cfg_err are 0 and mod_ctl is 1 exactly when RST_A is nonzero. The first period after reset uses N = RST_N and A = RST_A (defaults 5 and 0), so fp is first high in cycle 64·RST_N + RST_A − 1, counting the first cycle with rst low as cycle 0.
- R2: With a valid pair (A, N) in use, consecutive fp pulses are 64·N + A input clock cycles apart.
- R3: In each period mod_ctl is 1 for the first 65·A cycles and 0 for the other 64·(N−A) cycles. It rises only in the first cycle of a period.
- R4: fp is high for exactly one clock cycle per period: the period's last cycle.
- R5: When load is high at a clock edge, swallow_in and main_in are captured. A pair captured in a cycle where fp is low is used from the period that starts after the next fp. The period in progress keeps its old length.
- R6: A pair captured in the same cycle as fp is not used at that boundary. The following period keeps the old ratio, and the pair takes effect at the boundary after that.
- R7: A pair with main_in below 5 sets cfg_err in the cycle after the load. At the boundary it is discarded and the ratio in use is unchanged.
- R8: A pair with main_in smaller than swallow_in is treated in the same way as R7: cfg_err is set and the pair is never used.
- R9: A load of a valid pair clears cfg_err in the cycle after the load. Without a load, cfg_err holds its value.
- R10: If several loads occur before a boundary, only the last captured pair is considered at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for swallow_in and main_in |
| swallow_in | input | A_W (6) | Swallow value A |
| main_in | input | N_W (12) | Main counter value N |
| mod_ctl | output | 1 | Prescaler modulus select: 1 = divide by 65, 0 = divide by 64 |
| fp | output | 1 | Divided output, high in the last cycle of each period |
| cfg_err | output | 1 | Last captured pair is invalid (N < 5 or N < A) |

## Verification
Two functions can fall in the same cycle: a period boundary, where the ratio is reloaded, and a load strobe that writes the holding register. The bench provokes this by raising load in the very cycle in which it sees fp high. It then measures the next two periods. The first must still have the old length and the old mod_ctl count, and only the second may show the new pair. Loads placed one cycle after fp and in mid-period are swept across every valid pair with N from 5 to 9. In each case the bench compares the measured period length and high time of mod_ctl with 64·N + A and 65·A.

// File: rtl/psd_pkg.sv
package psd_pkg;

  // Total division ratio of one output period
  function automatic int unsigned div_ratio(input int unsigned n, input int unsigned a,
                                            input int unsigned pre_w);
    return (n << pre_w) + a;
  endfunction

  // A pair is usable when N reaches the floor and is not smaller than A
  function automatic logic cfg_ok(input int unsigned n, input int unsigned a,
                                  input int unsigned min_n);
    return (n >= min_n) && (n >= a);
  endfunction

  // Start value of the prescaler down-counter for the chosen modulus
  function automatic int unsigned pre_top(input int unsigned pre_w, input logic mod_hi);
    return mod_hi ? (32'd1 << pre_w) : ((32'd1 << pre_w) - 32'd1);
  endfunction

endpackage

// File: rtl/psd_cfg.sv
module psd_cfg
  import psd_pkg::*;
#(
  parameter int unsigned A_W   = 6,
  parameter int unsigned N_W   = 12,
  parameter int unsigned MIN_N = 5,
  parameter int unsigned RST_A = 0,
  parameter int unsigned RST_N = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [N_W-1:0] n_in,
  input  logic           boundary,
  output logic [A_W-1:0] act_a,
  output logic [N_W-1:0] act_n,
  output logic [A_W-1:0] nxt_a,
  output logic [N_W-1:0] nxt_n,
  output logic           cfg_err
);

  logic [A_W-1:0] pend_a;
  logic [N_W-1:0] pend_n;
  logic           pend_vld;
  logic           pend_ok;
  logic           in_ok;
  logic           adopt;

  assign pend_ok = cfg_ok(32'(pend_n), 32'(pend_a), MIN_N);
  assign in_ok   = cfg_ok(32'(n_in), 32'(a_in), MIN_N);
  assign adopt   = boundary && pend_vld && pend_ok;
  assign nxt_a   = adopt ? pend_a : act_a;
  assign nxt_n   = adopt ? pend_n : act_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a   <= A_W'(RST_A);
      pend_n   <= N_W'(RST_N);
      pend_vld <= 1'b0;
      act_a    <= A_W'(RST_A);
      act_n    <= N_W'(RST_N);
      cfg_err  <= 1'b0;
    end else begin
      if (load) begin
        pend_a   <= a_in;
        pend_n   <= n_in;
        pend_vld <= 1'b1;
        cfg_err  <= !in_ok;
      end else if (boundary) begin
        pend_vld <= 1'b0;
      end
      act_a <= nxt_a;
      act_n <= nxt_n;
    end
  end

  // R5: the ratio in use moves only at a period boundary
  assert_ratio_steady_R5: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> ($stable(act_a) && $stable(act_n)));

  // R7: an unusable pair never becomes the ratio in use
  assert_active_valid_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_ok(32'(act_n), 32'(act_a), MIN_N));

  // R9: the error flag only moves on a load
  assert_err_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cfg_err));

endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned PRE_W  = 6,
  parameter bit          RST_HI = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic reload_hi,
  output logic tick
);

  localparam int unsigned PC_W   = PRE_W + 1;
  localparam logic [PC_W-1:0] TOP_HI = PC_W'(pre_top(PRE_W, 1'b1));
  localparam logic [PC_W-1:0] TOP_LO = PC_W'(pre_top(PRE_W, 1'b0));

  logic [PC_W-1:0] pc;

  assign tick = (pc == '0);

  always_ff @(posedge clk) begin
    if (rst)       pc <= RST_HI ? TOP_HI : TOP_LO;
    else if (tick) pc <= reload_hi ? TOP_HI : TOP_LO;
    else           pc <= pc - 1'b1;
  end

  // R3: the prescaler never counts past the larger modulus
  assert_pc_range_R3: assert property (@(posedge clk) disable iff (rst)
    pc <= TOP_HI);

endmodule

// File: rtl/psd_counters.sv
module psd_counters #(
  parameter int unsigned A_W   = 6,
  parameter int unsigned N_W   = 12,
  parameter int unsigned RST_A = 0,
  parameter int unsigned RST_N = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [A_W-1:0] nxt_a,
  input  logic [N_W-1:0] nxt_n,
  output logic           mod_ctl,
  output logic           period_end,
  output logic           reload_hi
);

  logic [A_W-1:0] sc;
  logic [N_W-1:0] mc;

  assign mod_ctl    = (sc != '0);
  assign period_end = tick && (mc == N_W'(1));
  assign reload_hi  = period_end ? (nxt_a != '0) : (sc > A_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sc <= A_W'(RST_A);
      mc <= N_W'(RST_N);
    end else if (period_end) begin
      sc <= nxt_a;
      mc <= nxt_n;
    end else if (tick) begin
      if (sc != '0) sc <= sc - 1'b1;
      mc <= mc - 1'b1;
    end
  end

  // R2: the main counter never sits at zero
  assert_mc_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    mc != '0);

  // R5: a boundary reloads the main counter with the chosen ratio
  assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
    period_end |=> (mc == $past(nxt_n)));

  // R3: modulus 65 ends only on a prescaler tick
  assert_mod_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mod_ctl) |-> $past(tick));

  // R3: modulus 65 starts only at a period boundary
  assert_mod_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_ctl) |-> $past(period_end));

endmodule

// File: rtl/psd_divider.sv
module psd_divider
  import psd_pkg::*;
#(
  parameter int unsigned PRE_W = 6,
  parameter int unsigned A_W   = 6,
  parameter int unsigned N_W   = 12,
  parameter int unsigned MIN_N = 5,
  parameter int unsigned RST_N = 5,
  parameter int unsigned RST_A = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] swallow_in,
  input  logic [N_W-1:0] main_in,
  output logic           mod_ctl,
  output logic           fp,
  output logic           cfg_err
);

  localparam bit RST_HI = (RST_A != 0);

  logic           tick;
  logic           period_end;
  logic           reload_hi;
  logic [A_W-1:0] act_a;
  logic [N_W-1:0] act_n;
  logic [A_W-1:0] nxt_a;
  logic [N_W-1:0] nxt_n;

  psd_cfg #(
    .A_W(A_W), .N_W(N_W), .MIN_N(MIN_N), .RST_A(RST_A), .RST_N(RST_N)
  ) u_cfg (
    .clk(clk), .rst(rst), .load(load), .a_in(swallow_in), .n_in(main_in),
    .boundary(period_end), .act_a(act_a), .act_n(act_n),
    .nxt_a(nxt_a), .nxt_n(nxt_n), .cfg_err(cfg_err)
  );

  psd_prescaler #(
    .PRE_W(PRE_W), .RST_HI(RST_HI)
  ) u_pre (
    .clk(clk), .rst(rst), .reload_hi(reload_hi), .tick(tick)
  );

  psd_counters #(
    .A_W(A_W), .N_W(N_W), .RST_A(RST_A), .RST_N(RST_N)
  ) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .nxt_a(nxt_a), .nxt_n(nxt_n),
    .mod_ctl(mod_ctl), .period_end(period_end), .reload_hi(reload_hi)
  );

  assign fp = period_end;

  // Cycle count inside the current period, kept for the length check
  logic [31:0] cyc;
  always_ff @(posedge clk) begin
    if (rst || period_end) cyc <= '0;
    else                   cyc <= cyc + 32'd1;
  end

  // R2: each period lasts exactly the programmed ratio
  assert_period_len_R2: assert property (@(posedge clk) disable iff (rst)
    period_end |-> ((cyc + 32'd1) == div_ratio(32'(act_n), 32'(act_a), PRE_W)));

  // R4: fp is never high in two consecutive cycles
  assert_fp_single_R4: assert property (@(posedge clk) disable iff (rst)
    fp |=> !fp);

endmodule

// File: tb/psd_divider_test.sv
module psd_divider_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [5:0]  swallow_in = '0;
  logic [11:0] main_in = '0;
  logic        mod_ctl, fp, cfg_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  psd_divider uut (
    .clk(clk), .rst(rst), .load(load), .swallow_in(swallow_in),
    .main_in(main_in), .mod_ctl(mod_ctl), .fp(fp), .cfg_err(cfg_err)
  );

  // Period monitor sampled on the falling edge
  int cnt = 0, mcnt = 0, last_len = 0, last_mod = 0, nper = 0, dbl_fp = 0;
  logic fp_prev = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      cnt = 0; mcnt = 0; fp_prev = 1'b0;
    end else begin
      cnt++;
      if (mod_ctl) mcnt++;
      if (fp && fp_prev) dbl_fp++;
      fp_prev = fp;
      if (fp) begin
        last_len = cnt; last_mod = mcnt; cnt = 0; mcnt = 0; nper++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_period();
    int p = nper;
    do begin
      @(negedge clk); #1;
    end while (nper == p);
  endtask

  task automatic load_cfg(input int n, input int a);
    @(negedge clk); #1;
    load = 1'b1; main_in = 12'(n); swallow_in = 6'(a);
    @(negedge clk); #1;
    load = 1'b0;
  endtask

  function automatic int ratio(input int n, input int a);
    return n * 64 + a;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check("R1 fp in reset", int'(fp), 0);
    check("R1 mod_ctl in reset", int'(mod_ctl), 0);
    check("R1 cfg_err in reset", int'(cfg_err), 0);
    @(negedge clk); #1 rst = 1'b0;
    // The first cycle with rst low is not counted by the monitor
    next_period();
    check("R1 first period length", last_len, ratio(5, 0) - 1);
    check("R1 first period mod_ctl", last_mod, 0);

    // R2/R3 sweep of every valid pair for N 5..9
    for (int n = 5; n <= 9; n++) begin
      for (int a = 0; a <= n; a++) begin
        load_cfg(n, a);
        next_period();
        next_period();
        check("R2 period length", last_len, ratio(n, a));
        check("R3 mod_ctl high time", last_mod, 65 * a);
      end
    end

    // Largest swallow value
    load_cfg(63, 63); next_period(); next_period();
    check("R2 N=A=63 length", last_len, ratio(63, 63));
    check("R3 N=A=63 mod_ctl", last_mod, 65 * 63);
    load_cfg(64, 63); next_period(); next_period();
    check("R2 N=64 A=63 length", last_len, ratio(64, 63));

    // R5: mid-period load leaves the current period alone
    load_cfg(6, 1); next_period(); next_period();
    repeat (40) @(negedge clk);
    load_cfg(9, 1);
    next_period();
    check("R5 period in progress", last_len, ratio(6, 1));
    next_period();
    check("R5 new pair in use", last_len, ratio(9, 1));

    // R6: load in the same cycle as fp
    load_cfg(6, 1); next_period(); next_period();
    load = 1'b1; main_in = 12'd7; swallow_in = 6'd3;
    @(negedge clk); #1 load = 1'b0;
    next_period();
    check("R6 boundary load deferred", last_len, ratio(6, 1));
    check("R6 deferred mod_ctl", last_mod, 65 * 1);
    next_period();
    check("R6 pair used one boundary later", last_len, ratio(7, 3));

    // R10: last of several loads wins
    load_cfg(8, 2);
    load_cfg(5, 4);
    next_period(); next_period();
    check("R10 last load wins", last_len, ratio(5, 4));

    // R7: N below the floor
    load_cfg(4, 0);
    check("R7 cfg_err set", int'(cfg_err), 1);
    next_period(); next_period();
    check("R7 ratio unchanged", last_len, ratio(5, 4));

    // R9: valid load clears the flag
    load_cfg(6, 0);
    check("R9 cfg_err cleared", int'(cfg_err), 0);
    next_period(); next_period();
    check("R9 valid pair used", last_len, ratio(6, 0));

    // R8: N smaller than A
    load_cfg(5, 6);
    check("R8 cfg_err set", int'(cfg_err), 1);
    repeat (3) @(negedge clk);
    #1 check("R9 cfg_err holds", int'(cfg_err), 1);
    next_period(); next_period();
    check("R8 ratio unchanged", last_len, ratio(6, 0));
    check("R8 mod_ctl unchanged", last_mod, 0);

    check("R4 fp single cycle", dbl_fp, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule